// File: doc/BRIEF.md
# Tick-Driven Decrementer with Auto-Reload

This block is a down-counter that software loads with a start value and that steps down by one on every cycle in which the tick-enable input is high. The tick input is meant to pulse at the time-base rate, so the counter runs at the same frequency as the time base. When a tick takes the count from one to zero, the block records an expiry. It sets a sticky status flag, and that flag drives a level interrupt whenever the interrupt-enable control bit is set.

Software reaches the block through a single-cycle write port. A select field chooses one of four targets: the count, the reload value, the control word, or the write-one-to-clear status word. When auto-reload is on and the reload value is nonzero, the expiry loads the reload value in place of zero, and the counter goes on running. In every other case the counter stops at zero and raises no further events. It starts again only when software writes a nonzero count.

Top module: `tdec_top`

## Requirements
- R1: After synchronous reset the count, the control bits, the reload value and the status word are all zero, and `irq_o` is low.
- R2: In a cycle with `tick_en` high, no count write and a nonzero count, the count drops by exactly one. In a cycle with `tick_en` low, the count holds.
- R3: An expiry occurs when a tick moves the count from 1 to 0. It sets status bit 27 in the same clock edge that updates the count. Writing zero to the count does not count as an expiry.
- R4: If auto-reload does not apply, the count stays at zero after expiry and further ticks cause no new expiry. A later write of a nonzero count makes the counter run and expire again.
- R5: When control bit 22 (auto-reload) is set and the reload value is nonzero, the expiry loads the count with the reload value.
- R6: When auto-reload is set but the reload value is zero, the count stays at zero after expiry and raises no further events.
- R7: `irq_o` is a registered level equal to status bit 27 AND control bit 26 (interrupt enable). It follows a change of either one at the same clock edge.
- R8: A status write clears bit 27 only when bit 27 of the write data is one. A write with that bit at zero leaves the status unchanged.
- R9: A count write takes priority over both decrementing and reloading in the same cycle, and it suppresses the expiry in that cycle.
- R10: If an expiry and a status clear happen in the same cycle, status bit 27 ends up set.
- R11: `wr_sel` encodes the write target as 0 for count, 1 for reload value, 2 for control and 3 for status. A write to one target leaves the count unchanged unless the target is the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base tick; one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 reload, 2 control, 3 status |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count |
| status_o | output | CNT_W | Status word; bit 27 is the expiry flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit count, interrupt enable at control bit 26, auto-reload at bit 22 and the expiry flag at status bit 27. Small loaded values bring expiry, reload and hold-at-zero within reach in a few ticks. A load of all ones followed by a single tick exercises the full counter width. The same-cycle collisions, a count write against a tick and an expiry against a status clear, are driven on purpose to exercise the priority rules.

// File: rtl/tdec_pkg.sv
package tdec_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STAT   = 2'd3
  } tdec_sel_e;
endpackage

// File: rtl/tdec_counter.sv
module tdec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             reload_take;

  always_comb begin
    expire_o    = tick_i && !wr_i && (cnt_q == ONE);
    reload_take = reload_en_i && (reload_val_i != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wr_data_i;
    end else if (expire_o) begin
      cnt_q <= reload_take ? reload_val_i : '0;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign count_o = cnt_q;

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !wr_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !wr_i) |=> $stable(cnt_q)); // R2
  AST_ZERO_STICKS: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !wr_i) |=> (cnt_q == '0)); // R4
  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (expire_o && reload_en_i && reload_val_i != '0) |=> (cnt_q == $past(reload_val_i))); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (cnt_q == $past(wr_data_i))); // R9
endmodule

// File: rtl/tdec_regs.sv
module tdec_regs
  import tdec_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int IE_BIT  = 26,
  parameter int ARE_BIT = 22,
  parameter int EXP_BIT = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             expire_i,
  output logic [CNT_W-1:0] reload_o,
  output logic             reload_en_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic             ie_q, are_q, flag_q, irq_q;
  logic             ie_n, are_n, flag_n, clr;
  logic [CNT_W-1:0] reload_q;

  always_comb begin
    ie_n  = ie_q;
    are_n = are_q;
    if (wr_en && wr_sel == SEL_CTRL) begin
      ie_n  = wr_data[IE_BIT];
      are_n = wr_data[ARE_BIT];
    end
    clr    = wr_en && (wr_sel == SEL_STAT) && wr_data[EXP_BIT];
    flag_n = (flag_q && !clr) || expire_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q     <= 1'b0;
      are_q    <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      ie_q   <= ie_n;
      are_q  <= are_n;
      flag_q <= flag_n;
      irq_q  <= flag_n && ie_n;
      if (wr_en && wr_sel == SEL_RELOAD) reload_q <= wr_data;
    end
  end

  assign reload_o    = reload_q;
  assign reload_en_o = are_q;
  assign flag_o      = flag_q;
  assign irq_o       = irq_q;

  AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> flag_q); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (expire_i && wr_en && wr_sel == SEL_STAT) |=> flag_q); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q && ie_q)); // R7
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (flag_q && wr_en && wr_sel == SEL_STAT && !wr_data[EXP_BIT]) |=> flag_q); // R8
endmodule

// File: rtl/tdec_top.sv
module tdec_top
  import tdec_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int IE_BIT  = 26,
  parameter int ARE_BIT = 22,
  parameter int EXP_BIT = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] status_o,
  output logic             irq_o
);
  logic             wr_cnt, expire, reload_en, flag;
  logic [CNT_W-1:0] reload_val;

  assign wr_cnt = wr_en && (wr_sel == SEL_COUNT);

  tdec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_en), .wr_i(wr_cnt), .wr_data_i(wr_data),
    .reload_en_i(reload_en), .reload_val_i(reload_val),
    .count_o(count_o), .expire_o(expire)
  );

  tdec_regs #(.CNT_W(CNT_W), .IE_BIT(IE_BIT), .ARE_BIT(ARE_BIT), .EXP_BIT(EXP_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .expire_i(expire), .reload_o(reload_val), .reload_en_o(reload_en),
    .flag_o(flag), .irq_o(irq_o)
  );

  always_comb begin
    status_o          = '0;
    status_o[EXP_BIT] = flag;
  end

  AST_NONCOUNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel != SEL_COUNT && !tick_en) |=> $stable(count_o)); // R11
endmodule

// File: tb/sim_tdec_top.sv
module sim_tdec_top;
  localparam int W = 32;
  localparam logic [W-1:0] IE  = 32'h1 << 26;
  localparam logic [W-1:0] ARE = 32'h1 << 22;
  localparam logic [W-1:0] EXP = 32'h1 << 27;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count_o, status_o;
  logic         irq_o;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  tdec_top u0 (.clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
               .wr_data(wr_data), .count_o(count_o), .status_o(status_o), .irq_o(irq_o));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", count_o, '0);
    check("R1 status", status_o, '0);
    check("R1 irq", {31'b0, irq_o}, 32'd1 & 32'd0);
  endtask

  task automatic t_decrement();
    wr(2'd0, 32'd5);
    ticks(2);
    check("R2 two ticks", count_o, 32'd3);
    repeat (3) @(negedge clk);
    check("R2 idle hold", count_o, 32'd3);
    wr(2'd2, IE);
    wr(2'd1, 32'd77);
    check("R11 non-count writes keep count", count_o, 32'd3);
    wr(2'd0, 32'hFFFF_FFFF);
    ticks(1);
    check("R2 full width", count_o, 32'hFFFF_FFFE);
  endtask

  task automatic t_expire_hold();
    wr(2'd0, 32'd3);
    ticks(3);
    check("R3 count zero", count_o, '0);
    check("R3 flag set", status_o, EXP);
    check("R7 irq on", {31'b0, irq_o}, 32'd1);
    wr(2'd3, EXP);
    check("R8 clear", status_o, '0);
    check("R7 irq off", {31'b0, irq_o}, 32'd0);
    ticks(4);
    check("R4 stays zero", count_o, '0);
    check("R4 no refire", status_o, '0);
    wr(2'd0, 32'd2);
    ticks(2);
    check("R4 refire after write", status_o, EXP);
    wr(2'd3, ~EXP);
    check("R8 zero bit ignored", status_o, EXP);
    wr(2'd3, EXP);
    wr(2'd0, 32'd0);
    check("R3 zero write no event", status_o, '0);
  endtask

  task automatic t_reload();
    wr(2'd1, 32'd4);
    wr(2'd2, ARE | IE);
    wr(2'd0, 32'd2);
    ticks(2);
    check("R5 reloaded", count_o, 32'd4);
    check("R5 flag", status_o, EXP);
    ticks(3);
    check("R5 running", count_o, 32'd1);
    ticks(1);
    check("R5 reload again", count_o, 32'd4);
    wr(2'd1, 32'd0);
    wr(2'd3, EXP);
    wr(2'd0, 32'd1);
    ticks(1);
    check("R6 zero reload count", count_o, '0);
    check("R6 flag", status_o, EXP);
    wr(2'd3, EXP);
    ticks(5);
    check("R6 no refire", status_o, '0);
    check("R6 stays zero", count_o, '0);
  endtask

  task automatic t_irq_mask();
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd1);
    ticks(1);
    check("R7 masked flag", status_o, EXP);
    check("R7 masked irq", {31'b0, irq_o}, 32'd0);
    wr(2'd2, IE);
    check("R7 enable raises irq", {31'b0, irq_o}, 32'd1);
    wr(2'd3, EXP);
  endtask

  task automatic t_collisions();
    wr(2'd1, 32'd6);
    wr(2'd2, ARE);
    wr(2'd0, 32'd1);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'd9;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    check("R9 write beats reload", count_o, 32'd9);
    check("R9 no expiry", status_o, '0);
    wr(2'd0, 32'd1);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = EXP;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    check("R10 set wins", status_o, EXP);
    check("R10 reload also taken", count_o, 32'd6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decrement();
    t_expire_hold();
    t_reload();
    t_irq_mask();
    t_collisions();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule